// File: doc/BRIEF.md
# NAND Page Buffer Cache Controller

This block turns byte-granular host reads and writes into page-level work on a NAND device's on-chip page buffer. A host address is cut into a page number (the upper bits) and a byte offset within the page (the lower bits). The controller keeps one tag with the page now in the device buffer and a flag that marks that copy as changed. A request that hits the resident page costs one byte command. A miss loads the new page first. If the old copy was changed, the miss first writes that page back to the array and waits for it to finish.

Commands go to a downstream NAND command engine through a valid/ready handshake, and the controller waits for the engine's done pulse before it sends anything else. Each page has 2048 data bytes followed by 64 spare bytes. The device-side column field is wide enough for the spare area, but host addresses reach only the data area. A flush request writes a changed page back and then answers with a done pulse. The host holds its request until it is acknowledged and is stalled while a page swap runs.

Top module: `nand_pc_cache`

## Requirements
- R1: The host address is split with the page number in bits [ADDR_W-1:COL_W] and the byte offset in bits [COL_W-1:0]. The offset is zero-extended onto the wider device column field, so byte commands always carry a column below PAGE_BYTES. Page commands carry column 0.
- R2: After reset no page is resident and the buffer is clean, with cmd_valid, hack and flush_done all low. The first host access therefore begins with a page load.
- R3: An access to the resident page issues exactly one byte command, with no page load and no page commit.
- R4: A miss while the buffer is clean issues a page load of the new page, then the byte command.
- R5: A miss while the buffer is changed issues a commit of the old page and waits for its done pulse. It then issues the page load of the new page, and the committed data persists in the array.
- R6: A host write marks the buffer changed. Several writes to the resident page lead to just one later commit.
- R7: A flush request while the buffer is changed issues one commit of the resident page and then pulses flush_done. A second flush afterwards issues no command.
- R8: A flush request while the buffer is clean pulses flush_done without issuing any command.
- R9: While cmd_valid is high and cmd_ready is low, the command fields hold steady. No new command is raised between acceptance and the engine's eng_done pulse.
- R10: hack is a one-cycle pulse. A read returns on hrdata during that pulse the byte last written to that address, or 0xFF for a page never written.
- R11: The cmd_op encoding is: 0 = load page into buffer, 1 = read buffer byte, 2 = write buffer byte, 3 = commit buffer to page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hreq | input | 1 | Host request, held until hack |
| hwe | input | 1 | Host write (1) or read (0) |
| haddr | input | ROW_W+COL_W | Host byte address |
| hwdata | input | DATA_W | Host write byte |
| hack | output | 1 | One-cycle acknowledge of a host request |
| hrdata | output | DATA_W | Read byte, valid with hack |
| flush_req | input | 1 | Flush request, held until flush_done |
| flush_done | output | 1 | One-cycle flush completion pulse |
| cmd_valid | output | 1 | Command to the NAND engine is valid |
| cmd_ready | input | 1 | NAND engine accepts the command |
| cmd_op | output | 2 | Command opcode (see R11) |
| cmd_row | output | ROW_W | Page number of the command |
| cmd_col | output | DCOL_W | Device column of the command |
| cmd_wdata | output | DATA_W | Byte for a buffer write command |
| eng_done | input | 1 | Engine completion pulse for the accepted command |
| eng_rdata | input | DATA_W | Byte returned with eng_done for a buffer read |

## Verification
The hardest situation to reach is a miss while the buffer holds changed data, where the commit of the old page must finish before the new load starts. The stimulus writes into one page and then reads a different page. It checks the order of commands logged by the engine model and then reads the first page back to confirm the write-back. A behavioural engine varies its ready stall and done latency from command to command, so the hold rules of the handshake are exercised with stalls of zero, one and two cycles.

// File: rtl/nand_pc_pkg.sv
`timescale 1ns/1ps
package nand_pc_pkg;
   typedef enum logic [1:0] {
      OP_LOAD_PAGE   = 2'd0,
      OP_READ_BYTE   = 2'd1,
      OP_WRITE_BYTE  = 2'd2,
      OP_COMMIT_PAGE = 2'd3
   } nand_op_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CMD,
      ST_WAIT,
      ST_HACK,
      ST_FDONE
   } ctl_state_e;
endpackage

// File: rtl/nand_pc_addr_split.sv
`timescale 1ns/1ps
module nand_pc_addr_split #(
   parameter int ROW_W  = 6,
   parameter int COL_W  = 11,
   parameter int DCOL_W = 12
) (
   input  logic [ROW_W+COL_W-1:0] addr,
   output logic [ROW_W-1:0]       row,
   output logic [DCOL_W-1:0]      dcol
);
   assign row = addr[ROW_W+COL_W-1:COL_W];

   generate
      if (DCOL_W > COL_W) begin : g_widen
         assign dcol = {{(DCOL_W-COL_W){1'b0}}, addr[COL_W-1:0]};
      end else if (DCOL_W == COL_W) begin : g_same
         assign dcol = addr[COL_W-1:0];
      end else begin : g_bad
         assign dcol = '0;
         $error("device column narrower than host offset");
      end
   endgenerate
endmodule

// File: rtl/nand_pc_tag.sv
`timescale 1ns/1ps
module nand_pc_tag #(
   parameter int ROW_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_en,
   input  logic [ROW_W-1:0] load_row,
   input  logic             write_en,
   input  logic             commit_en,
   input  logic [ROW_W-1:0] query_row,
   output logic             valid,
   output logic [ROW_W-1:0] row,
   output logic             dirty,
   output logic             hit
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid <= 1'b0;
         row   <= '0;
         dirty <= 1'b0;
      end else begin
         if (load_en) begin
            valid <= 1'b1;
            row   <= load_row;
            dirty <= 1'b0;
         end
         if (write_en)  dirty <= 1'b1;
         if (commit_en) dirty <= 1'b0;
      end
   end

   assign hit = valid && (row == query_row);

   // a buffer byte may only be changed when a page is resident
   assert_write_resident_R6: assert property (@(posedge clk) disable iff (!rst_n)
      write_en |-> valid);
   // a load must never discard changed buffer contents
   assert_load_over_clean_R5: assert property (@(posedge clk) disable iff (!rst_n)
      load_en |-> !dirty);
endmodule

// File: rtl/nand_pc_cache.sv
`timescale 1ns/1ps
module nand_pc_cache
   import nand_pc_pkg::*;
#(
   parameter int ROW_W       = 6,
   parameter int PAGE_BYTES  = 2048,
   parameter int SPARE_BYTES = 64,
   parameter int DATA_W      = 8,
   localparam int COL_W      = $clog2(PAGE_BYTES),
   localparam int DCOL_W     = $clog2(PAGE_BYTES + SPARE_BYTES),
   localparam int ADDR_W     = ROW_W + COL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hreq,
   input  logic              hwe,
   input  logic [ADDR_W-1:0] haddr,
   input  logic [DATA_W-1:0] hwdata,
   output logic              hack,
   output logic [DATA_W-1:0] hrdata,
   input  logic              flush_req,
   output logic              flush_done,
   output logic              cmd_valid,
   input  logic              cmd_ready,
   output logic [1:0]        cmd_op,
   output logic [ROW_W-1:0]  cmd_row,
   output logic [DCOL_W-1:0] cmd_col,
   output logic [DATA_W-1:0] cmd_wdata,
   input  logic              eng_done,
   input  logic [DATA_W-1:0] eng_rdata
);
   generate
      if (PAGE_BYTES != (1 << COL_W)) begin : g_chk_pow2
         $error("PAGE_BYTES must be a power of two");
      end
      if (ROW_W < 1) begin : g_chk_row
         $error("ROW_W must be at least 1");
      end
      if (SPARE_BYTES < 0) begin : g_chk_spare
         $error("SPARE_BYTES must not be negative");
      end
   endgenerate

   ctl_state_e          state;
   nand_op_e            op_q;
   logic [ROW_W-1:0]    row_q, req_row;
   logic [DCOL_W-1:0]   col_q, req_col;
   logic [DATA_W-1:0]   req_wdata, rdata_q;
   logic                req_we, flushing;

   logic [ROW_W-1:0]    a_row;
   logic [DCOL_W-1:0]   a_col;
   logic                t_valid, t_dirty, t_hit;
   logic [ROW_W-1:0]    t_row;
   logic                fin;

   nand_pc_addr_split #(.ROW_W(ROW_W), .COL_W(COL_W), .DCOL_W(DCOL_W)) u_split (
      .addr(haddr), .row(a_row), .dcol(a_col));

   assign fin = (state == ST_WAIT) && eng_done;

   nand_pc_tag #(.ROW_W(ROW_W)) u_tag (
      .clk(clk), .rst_n(rst_n),
      .load_en(fin && op_q == OP_LOAD_PAGE), .load_row(row_q),
      .write_en(fin && op_q == OP_WRITE_BYTE),
      .commit_en(fin && op_q == OP_COMMIT_PAGE),
      .query_row(a_row),
      .valid(t_valid), .row(t_row), .dirty(t_dirty), .hit(t_hit));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         op_q      <= OP_LOAD_PAGE;
         row_q     <= '0;
         col_q     <= '0;
         req_row   <= '0;
         req_col   <= '0;
         req_wdata <= '0;
         req_we    <= 1'b0;
         rdata_q   <= '0;
         flushing  <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (hreq) begin
                  req_we    <= hwe;
                  req_row   <= a_row;
                  req_col   <= a_col;
                  req_wdata <= hwdata;
                  flushing  <= 1'b0;
                  state     <= ST_CMD;
                  if (t_hit) begin
                     op_q  <= hwe ? OP_WRITE_BYTE : OP_READ_BYTE;
                     row_q <= a_row;
                     col_q <= a_col;
                  end else if (t_dirty) begin
                     op_q  <= OP_COMMIT_PAGE;
                     row_q <= t_row;
                     col_q <= '0;
                  end else begin
                     op_q  <= OP_LOAD_PAGE;
                     row_q <= a_row;
                     col_q <= '0;
                  end
               end else if (flush_req) begin
                  flushing <= 1'b1;
                  if (t_dirty) begin
                     op_q  <= OP_COMMIT_PAGE;
                     row_q <= t_row;
                     col_q <= '0;
                     state <= ST_CMD;
                  end else begin
                     state <= ST_FDONE;
                  end
               end
            end
            ST_CMD: if (cmd_ready) state <= ST_WAIT;
            ST_WAIT: if (eng_done) begin
               case (op_q)
                  OP_COMMIT_PAGE: begin
                     if (flushing) begin
                        state <= ST_FDONE;
                     end else begin
                        op_q  <= OP_LOAD_PAGE;
                        row_q <= req_row;
                        col_q <= '0;
                        state <= ST_CMD;
                     end
                  end
                  OP_LOAD_PAGE: begin
                     op_q  <= req_we ? OP_WRITE_BYTE : OP_READ_BYTE;
                     col_q <= req_col;
                     state <= ST_CMD;
                  end
                  default: begin
                     if (op_q == OP_READ_BYTE) rdata_q <= eng_rdata;
                     state <= ST_HACK;
                  end
               endcase
            end
            ST_HACK: state <= ST_IDLE;
            ST_FDONE: begin
               flushing <= 1'b0;
               state    <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign cmd_valid  = (state == ST_CMD);
   assign cmd_op     = op_q;
   assign cmd_row    = row_q;
   assign cmd_col    = col_q;
   assign cmd_wdata  = req_wdata;
   assign hack       = (state == ST_HACK);
   assign hrdata     = rdata_q;
   assign flush_done = (state == ST_FDONE);

   assert_cmd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op) && $stable(cmd_row)
                                  && $stable(cmd_col) && $stable(cmd_wdata));
   assert_data_cols_only_R1: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && (cmd_op == OP_READ_BYTE || cmd_op == OP_WRITE_BYTE)
         |-> cmd_col < DCOL_W'(PAGE_BYTES));
   assert_byte_on_resident_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && (cmd_op == OP_READ_BYTE || cmd_op == OP_WRITE_BYTE)
         |-> t_valid && cmd_row == t_row);
   assert_commit_when_dirty_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_op == OP_COMMIT_PAGE |-> t_dirty && cmd_row == t_row);
   assert_ack_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      hack |=> !hack);
   assert_flush_leaves_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
      flush_done |-> !t_dirty);
endmodule

// File: tb/sim_nand_pc_cache.sv
`timescale 1ns/1ps
module sim_nand_pc_cache;
   localparam int ROW_W = 6;
   localparam int COL_W = 11;
   localparam int DCOL_W = 12;
   localparam int FULL = 2112;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic hreq = 1'b0, hwe = 1'b0;
   logic [ROW_W+COL_W-1:0] haddr = '0;
   logic [7:0] hwdata = '0;
   logic hack, flush_done, cmd_valid;
   logic [7:0] hrdata, cmd_wdata;
   logic flush_req = 1'b0;
   logic cmd_ready = 1'b0;
   logic [1:0] cmd_op;
   logic [ROW_W-1:0] cmd_row;
   logic [DCOL_W-1:0] cmd_col;
   logic eng_done = 1'b0;
   logic [7:0] eng_rdata = '0;

   int n_chk = 0, n_bad = 0;
   bit finished = 0;

   logic [7:0] arr [int];
   logic [7:0] pbuf [0:FULL-1];
   int lg_op[$], lg_row[$], lg_col[$];

   always #2 clk = ~clk;

   nand_pc_cache u0 (
      .clk(clk), .rst_n(rst_n), .hreq(hreq), .hwe(hwe), .haddr(haddr),
      .hwdata(hwdata), .hack(hack), .hrdata(hrdata), .flush_req(flush_req),
      .flush_done(flush_done), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_op(cmd_op), .cmd_row(cmd_row), .cmd_col(cmd_col),
      .cmd_wdata(cmd_wdata), .eng_done(eng_done), .eng_rdata(eng_rdata));

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] arr_rd(input int idx);
      return arr.exists(idx) ? arr[idx] : 8'hFF;
   endfunction

   // behavioural NAND engine: op codes per R11
   initial begin
      int cnt = 0;
      forever begin
         @(negedge clk);
         if (cmd_valid) begin
            int op, row, col, wd, stall, lat;
            op = cmd_op; row = cmd_row; col = cmd_col; wd = cmd_wdata;
            stall = cnt % 3; lat = 1 + (cnt % 2); cnt++;
            for (int s = 0; s < stall; s++) begin
               @(negedge clk);
               chk(cmd_valid && cmd_op == op && cmd_row == row && cmd_col == col
                   && cmd_wdata == wd, "R9", "fields held while stalled", cmd_row, row);
            end
            cmd_ready = 1'b1;
            @(negedge clk);
            cmd_ready = 1'b0;
            lg_op.push_back(op); lg_row.push_back(row); lg_col.push_back(col);
            case (op)
               0: for (int c = 0; c < FULL; c++) pbuf[c] = arr_rd(row * 4096 + c);
               1: eng_rdata = pbuf[col];
               2: pbuf[col] = wd[7:0];
               default: for (int c = 0; c < FULL; c++) arr[row * 4096 + c] = pbuf[c];
            endcase
            for (int l = 0; l < lat; l++) begin
               chk(!cmd_valid, "R9", "no command while busy", cmd_valid, 0);
               @(negedge clk);
            end
            eng_done = 1'b1;
            @(negedge clk);
            eng_done = 1'b0;
         end
      end
   end

   task automatic clear_log();
      lg_op.delete(); lg_row.delete(); lg_col.delete();
   endtask

   task automatic chk_entry(input string req, input int idx, input int op,
                            input int row, input int col);
      if (idx < lg_op.size()) begin
         chk(lg_op[idx] == op, req, "command opcode", lg_op[idx], op);
         chk(lg_row[idx] == row, req, "command page", lg_row[idx], row);
         chk(lg_col[idx] == col, req, "command column", lg_col[idx], col);
      end else begin
         chk(0, req, "missing command", lg_op.size(), idx + 1);
      end
   endtask

   task automatic host_op(input bit we, input int row, input int col,
                          input logic [7:0] wd, output logic [7:0] rd);
      int n = 0;
      @(negedge clk);
      hreq = 1'b1; hwe = we; haddr = {6'(row), 11'(col)}; hwdata = wd;
      @(negedge clk);
      while (!hack && n < 5000) begin @(negedge clk); n++; end
      rd = hrdata;
      hreq = 1'b0;
      @(negedge clk);
      chk(!hack, "R10", "ack lasts one cycle", hack, 0);
   endtask

   task automatic do_flush();
      int n = 0;
      @(negedge clk);
      flush_req = 1'b1;
      @(negedge clk);
      while (!flush_done && n < 5000) begin @(negedge clk); n++; end
      flush_req = 1'b0;
      @(negedge clk);
      chk(!flush_done, "R7", "flush_done lasts one cycle", flush_done, 0);
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk(!cmd_valid && !hack && !flush_done, "R2", "idle outputs in reset",
          {cmd_valid, hack, flush_done}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(!cmd_valid, "R2", "no command after reset", cmd_valid, 0);
   endtask

   task automatic t_first_read();
      logic [7:0] rd;
      clear_log();
      host_op(0, 3, 5, 8'h00, rd);
      chk(lg_op.size() == 2, "R2", "first access command count", lg_op.size(), 2);
      chk_entry("R4", 0, 0, 3, 0);
      chk_entry("R11", 1, 1, 3, 5);
      chk(rd == 8'hFF, "R10", "blank page reads 0xFF", rd, 8'hFF);
   endtask

   task automatic t_hit_edge();
      logic [7:0] rd;
      clear_log();
      host_op(0, 3, 2047, 8'h00, rd);
      chk(lg_op.size() == 1, "R3", "hit issues one command", lg_op.size(), 1);
      chk_entry("R1", 0, 1, 3, 2047);
   endtask

   task automatic t_writes();
      logic [7:0] rd;
      clear_log();
      host_op(1, 3, 10, 8'hA5, rd);
      host_op(1, 3, 0, 8'h3C, rd);
      chk(lg_op.size() == 2, "R6", "two writes two commands", lg_op.size(), 2);
      chk_entry("R6", 0, 2, 3, 10);
      chk_entry("R6", 1, 2, 3, 0);
      host_op(0, 3, 10, 8'h00, rd);
      chk(rd == 8'hA5, "R10", "read back written byte", rd, 8'hA5);
   endtask

   task automatic t_dirty_miss();
      logic [7:0] rd;
      clear_log();
      host_op(0, 7, 1, 8'h00, rd);
      chk(lg_op.size() == 3, "R5", "dirty miss command count", lg_op.size(), 3);
      chk_entry("R5", 0, 3, 3, 0);
      chk_entry("R5", 1, 0, 7, 0);
      chk_entry("R5", 2, 1, 7, 1);
      chk(arr_rd(3 * 4096 + 10) == 8'hA5, "R5", "written byte reached array",
          arr_rd(3 * 4096 + 10), 8'hA5);
      chk(arr_rd(3 * 4096) == 8'h3C, "R6", "second byte in same commit",
          arr_rd(3 * 4096), 8'h3C);
   endtask

   task automatic t_flush_clean();
      clear_log();
      do_flush();
      chk(lg_op.size() == 0, "R8", "clean flush issues nothing", lg_op.size(), 0);
   endtask

   task automatic t_flush_dirty();
      logic [7:0] rd;
      host_op(1, 7, 100, 8'h5A, rd);
      clear_log();
      do_flush();
      chk(lg_op.size() == 1, "R7", "dirty flush one commit", lg_op.size(), 1);
      chk_entry("R7", 0, 3, 7, 0);
      chk(arr_rd(7 * 4096 + 100) == 8'h5A, "R7", "flush data in array",
          arr_rd(7 * 4096 + 100), 8'h5A);
      clear_log();
      do_flush();
      chk(lg_op.size() == 0, "R7", "second flush issues nothing", lg_op.size(), 0);
   endtask

   task automatic t_clean_miss();
      logic [7:0] rd;
      clear_log();
      host_op(0, 3, 10, 8'h00, rd);
      chk(lg_op.size() == 2, "R4", "clean miss command count", lg_op.size(), 2);
      chk_entry("R4", 0, 0, 3, 0);
      chk(rd == 8'hA5, "R4", "reloaded page data", rd, 8'hA5);
   endtask

   task automatic t_top_address();
      logic [7:0] rd;
      clear_log();
      host_op(1, 63, 2047, 8'h77, rd);
      chk_entry("R1", 0, 0, 63, 0);
      chk_entry("R1", 1, 2, 63, 2047);
      host_op(0, 63, 2047, 8'h00, rd);
      chk(rd == 8'h77, "R1", "top address read back", rd, 8'h77);
      host_op(0, 0, 0, 8'h00, rd);
      chk(arr_rd(63 * 4096 + 2047) == 8'h77, "R5", "top page written back",
          arr_rd(63 * 4096 + 2047), 8'h77);
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      t_first_read();
      t_hit_edge();
      t_writes();
      t_dirty_miss();
      t_flush_clean();
      t_flush_dirty();
      t_clean_miss();
      t_top_address();
      finished = 1;
      summary();
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL R9 watchdog expired: actual 0 expected 1");
         summary();
         $finish;
      end
   end
endmodule